// File: doc/BRIEF.md
# Video Frame-Completion Interrupt Generator

This block sits beside a video AXI4-Stream link and only observes it; it never drives any stream signal. It counts completed video lines, where a line is one accepted beat that carries the end-of-line marker. When the count reaches a programmed per-frame line total, the block raises a frame-done flag. The rising edge of that flag becomes a single-cycle interrupt pulse. Software can use this pulse to learn that a frame buffer is free before the vertical blanking interval, rather than waiting for the first pixel of the next frame.

The start of a frame comes from the falling edge of one of two sync sources, chosen by configuration: a dedicated external sync pin, or the stream's start-of-frame user bit. A third setting, free-run, uses no sync source at all; in that setting the line counter wraps by itself whenever it reaches the programmed total. The block also keeps two sticky error bits. One flags a frame that was cut short by an early sync. The other flags a frame that carried more lines than programmed. Each bit is cleared by writing a one to its clear bit.

Top module: `frame_irq_gen`

## Requirements
- R1: After reset, frame_done is 1 and irq, err_short and err_long are 0. No interrupt pulse follows reset.
- R2: A line is counted only in a cycle where s_tvalid, s_tready and s_tlast are all 1. Any other combination leaves the count unchanged.
- R3: frame_done goes to 1 on the clock edge that registers the line which makes the count equal to the active programmed total.
- R4: cfg_sync_sel picks the sync source: 0 selects ext_sync and 1 selects s_tuser. The tuser level is sampled every cycle. A 1-to-0 transition of the selected source is a frame start. A frame start clears frame_done and restarts the count. In sync modes, frame_done is cleared by nothing else, and edges on the unselected source have no effect.
- R5: irq is high for exactly one cycle, in the cycle after frame_done rises. irq never fires while frame_done simply stays high.
- R6: With cfg_sync_sel equal to 2 or 3 (free-run), reaching the programmed total sets frame_done and restarts the count from zero. The next counted line clears frame_done.
- R7: A frame start that arrives while frame_done is 0 and the active total is nonzero sets err_short. A frame start that arrives while frame_done is 1 does not set it. err_short stays set until it is cleared.
- R8: In sync modes, a counted line that arrives while frame_done is 1 sets err_long. That line is not counted, frame_done stays 1 and no new interrupt occurs.
- R9: err_clr bit 0 clears err_short and err_clr bit 1 clears err_long. Each clear bit affects only its own error. A new error in the same cycle as its clear takes priority.
- R10: A change to cfg_lines takes effect only at the next frame start (or at the next wrap in free-run). A total of 0 means frame_done never asserts and no length errors are raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sync_sel | input | 2 | Frame-start source: 0 external, 1 tuser, 2/3 free-run |
| cfg_lines | input | LINE_W | Programmed lines per frame; 0 disables completion |
| ext_sync | input | 1 | External frame sync; falling edge starts a frame |
| s_tvalid | input | 1 | Observed stream valid |
| s_tready | input | 1 | Observed stream ready |
| s_tlast | input | 1 | Observed end-of-line marker |
| s_tuser | input | 1 | Observed start-of-frame bit |
| err_clr | input | 2 | Write-one-to-clear: bit 0 short error, bit 1 long error |
| frame_done | output | 1 | Frame-complete status flag |
| irq | output | 1 | One-cycle pulse on frame_done rising |
| err_short | output | 1 | Sticky short-frame error |
| err_long | output | 1 | Sticky overlong-frame error |

## Verification
A wrong line count shows up within one line time. The symptom is frame_done rising one beat early or late, with the irq pulse moving along with it. A lost or spurious sync edge shows up at the next frame boundary. It appears either as frame_done failing to clear or as err_short being set on a frame of correct length. A wrong latch of the programmed total, or a counter that keeps counting past completion, shows up only one frame later. There it appears as an unexpected err_long or as a completion at the old length, so the bench runs several consecutive frames after each configuration change.

// File: rtl/frame_irq_pkg.sv
package frame_irq_pkg;

    typedef enum logic [1:0] {
        SRC_EXT   = 2'd0,
        SRC_TUSER = 2'd1,
        SRC_FREE  = 2'd2,
        SRC_FREE2 = 2'd3
    } sync_src_e;

    typedef struct packed {
        logic long_f;
        logic short_f;
    } frame_err_t;

    function automatic logic fell(input logic prev_lvl, input logic cur_lvl);
        return prev_lvl & ~cur_lvl;
    endfunction

endpackage

// File: rtl/frame_sync_edge.sv
module frame_sync_edge
    import frame_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sync_src_e sel,
    input  logic      ext_sync,
    input  logic      tuser,
    output logic      sync_ev,
    output logic      free_run
);
    logic src_lvl;
    logic prev_q;

    always_comb begin
        unique case (sel)
            SRC_EXT:   src_lvl = ext_sync;
            SRC_TUSER: src_lvl = tuser;
            default:   src_lvl = 1'b0;
        endcase
    end

    assign free_run = (sel == SRC_FREE) || (sel == SRC_FREE2);

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= src_lvl;
    end

    assign sync_ev = fell(prev_q, src_lvl);

    // R4
    no_free_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (free_run && $past(free_run)) |-> !sync_ev);

endmodule

// File: rtl/frame_line_ctr.sv
module frame_line_ctr
    import frame_irq_pkg::*;
#(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              free_run,
    input  logic              sync_ev,
    input  logic              line_beat,
    input  logic [LINE_W-1:0] cfg_lines,
    input  frame_err_t        err_clr,
    output logic              done,
    output frame_err_t        err
);
    localparam logic [LINE_W-1:0] ZERO = '0;

    logic [LINE_W-1:0] cnt_q, cnt_d, tgt_q, tgt_d;
    logic [LINE_W-1:0] base_cnt, base_tgt, inc;
    logic              done_q, done_d, base_done;
    logic              short_hit, long_hit;
    frame_err_t        err_q, err_d;

    always_comb begin
        base_cnt  = sync_ev ? ZERO : cnt_q;
        base_tgt  = sync_ev ? cfg_lines : tgt_q;
        base_done = sync_ev ? 1'b0 : done_q;
        cnt_d     = base_cnt;
        tgt_d     = base_tgt;
        done_d    = base_done;
        inc       = base_cnt + 1'b1;
        short_hit = sync_ev && !done_q && (tgt_q != ZERO);
        long_hit  = 1'b0;
        if (free_run && base_tgt == ZERO) tgt_d = cfg_lines;
        if (line_beat) begin
            if (base_done && !free_run) begin
                long_hit = 1'b1;
            end else begin
                done_d = (base_tgt != ZERO) && (inc == base_tgt);
                if (free_run && done_d) begin
                    cnt_d = ZERO;
                    tgt_d = cfg_lines;
                end else begin
                    cnt_d = inc;
                end
            end
        end
        err_d.short_f = short_hit | (err_q.short_f & ~err_clr.short_f);
        err_d.long_f  = long_hit  | (err_q.long_f  & ~err_clr.long_f);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= ZERO;
            tgt_q  <= cfg_lines;
            done_q <= 1'b1;
            err_q  <= '0;
        end else begin
            cnt_q  <= cnt_d;
            tgt_q  <= tgt_d;
            done_q <= done_d;
            err_q  <= err_d;
        end
    end

    assign done = done_q;
    assign err  = err_q;

    // R8
    no_overcount_chk: assert property (@(posedge clk) disable iff (rst)
        (tgt_q != ZERO) |-> (cnt_q <= tgt_q));

    // R4
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done_q && !sync_ev && !free_run) |=> done_q);

    // R7
    short_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_q.short_f && !err_clr.short_f) |=> err_q.short_f);

    // R8
    long_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_q.long_f && !err_clr.long_f) |=> err_q.long_f);

endmodule

// File: rtl/frame_irq_edge.sv
module frame_irq_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic pulse
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b1;
        else     lvl_q <= level;
    end

    assign pulse = level & ~lvl_q;

    // R5
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

endmodule

// File: rtl/frame_irq_gen.sv
module frame_irq_gen
    import frame_irq_pkg::*;
#(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_sync_sel,
    input  logic [LINE_W-1:0] cfg_lines,
    input  logic              ext_sync,
    input  logic              s_tvalid,
    input  logic              s_tready,
    input  logic              s_tlast,
    input  logic              s_tuser,
    input  logic [1:0]        err_clr,
    output logic              frame_done,
    output logic              irq,
    output logic              err_short,
    output logic              err_long
);
    logic       sync_ev, free_run, line_beat;
    frame_err_t err, clr;

    assign line_beat = s_tvalid & s_tready & s_tlast;
    assign clr       = frame_err_t'(err_clr);

    frame_sync_edge u_sync (
        .clk      (clk),
        .rst      (rst),
        .sel      (sync_src_e'(cfg_sync_sel)),
        .ext_sync (ext_sync),
        .tuser    (s_tuser),
        .sync_ev  (sync_ev),
        .free_run (free_run)
    );

    frame_line_ctr #(.LINE_W(LINE_W)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .free_run  (free_run),
        .sync_ev   (sync_ev),
        .line_beat (line_beat),
        .cfg_lines (cfg_lines),
        .err_clr   (clr),
        .done      (frame_done),
        .err       (err)
    );

    frame_irq_edge u_irq (
        .clk   (clk),
        .rst   (rst),
        .level (frame_done),
        .pulse (irq)
    );

    assign err_short = err.short_f;
    assign err_long  = err.long_f;

    // R5
    irq_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> frame_done);

endmodule

// File: tb/frame_irq_gen_test.sv
module frame_irq_gen_test;
    localparam int LW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cfg_sync_sel = 2'd0;
    logic [LW-1:0] cfg_lines = 12'd3;
    logic          ext_sync = 1'b0, tv = 1'b0, tr = 1'b0, tl = 1'b0, tu = 1'b0;
    logic [1:0]    err_clr = 2'b00;
    logic          frame_done, irq, err_short, err_long;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    frame_irq_gen #(.LINE_W(LW)) uut (
        .clk(clk), .rst(rst), .cfg_sync_sel(cfg_sync_sel), .cfg_lines(cfg_lines),
        .ext_sync(ext_sync), .s_tvalid(tv), .s_tready(tr), .s_tlast(tl),
        .s_tuser(tu), .err_clr(err_clr), .frame_done(frame_done), .irq(irq),
        .err_short(err_short), .err_long(err_long)
    );

    // row bits: {tvalid,tready,tlast,tuser,ext_sync, exp_done, exp_irq}; external sync, 3 lines
    localparam logic [6:0] VEC [11] = '{
        7'b00001_10,  // ext high: no event
        7'b00000_00,  // ext falls: frame start (R4)
        7'b11100_00,  // line 1
        7'b10100_00,  // ready low: ignored (R2)
        7'b01100_00,  // valid low: ignored (R2)
        7'b11000_00,  // no tlast: ignored (R2)
        7'b11100_00,  // line 2
        7'b11100_11,  // line 3: done + irq (R3, R5)
        7'b00000_10,  // irq gone, done held (R5)
        7'b00001_10,  // rising edge: no clear (R4)
        7'b00000_00   // falling edge clears (R4)
    };

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic line;
        tv = 1'b1; tr = 1'b1; tl = 1'b1;
        tick;
        tv = 1'b0; tr = 1'b0; tl = 1'b0;
    endtask

    task automatic xsync;
        ext_sync = 1'b1; tick;
        ext_sync = 1'b0; tick;
    endtask

    task automatic usync;
        tu = 1'b1; tick;
        tu = 1'b0; tick;
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick; tick;
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 done", frame_done, 1'b1);
        chk("R1 irq", irq, 1'b0);
        chk("R1 err_short", err_short, 1'b0);
        chk("R1 err_long", err_long, 1'b0);

        for (int i = 0; i < 11; i++) begin
            {tv, tr, tl, tu, ext_sync} = VEC[i][6:2];
            tick;
            chk("R2/R3/R4 table done", frame_done, VEC[i][1]);
            chk("R5 table irq", irq, VEC[i][0]);
        end
        {tv, tr, tl, tu, ext_sync} = 5'b0;

        // R7 short frame
        line; xsync;
        chk("R7 short set", err_short, 1'b1);
        chk("R7 done low", frame_done, 1'b0);
        // R9 clear short
        err_clr = 2'b01; tick; err_clr = 2'b00;
        chk("R9 short cleared", err_short, 1'b0);

        // R8 overlong
        line; line; line;
        chk("R3 done", frame_done, 1'b1);
        line;
        chk("R8 long set", err_long, 1'b1);
        chk("R8 done held", frame_done, 1'b1);
        chk("R8 no irq", irq, 1'b0);

        // sync while done: no short error
        xsync;
        chk("R7 no short when done", err_short, 1'b0);
        line; xsync;
        chk("R7 short again", err_short, 1'b1);
        err_clr = 2'b10; tick; err_clr = 2'b00;
        chk("R9 long cleared", err_long, 1'b0);
        chk("R9 short kept", err_short, 1'b1);
        err_clr = 2'b01; tick; err_clr = 2'b00;

        // R4 tuser source
        line; line; line;
        chk("R3 done again", frame_done, 1'b1);
        cfg_sync_sel = 2'd1;
        xsync;
        chk("R4 ext ignored", frame_done, 1'b1);
        usync;
        chk("R4 tuser clears", frame_done, 1'b0);

        // R10 deferred line count
        cfg_lines = 12'd2;
        line; line;
        chk("R10 old total kept", frame_done, 1'b0);
        line;
        chk("R10 old total done", frame_done, 1'b1);
        usync; line; line;
        chk("R10 new total done", frame_done, 1'b1);

        // R10 zero disables
        cfg_lines = 12'd0;
        usync;
        for (int k = 0; k < 5; k++) line;
        chk("R10 zero no done", frame_done, 1'b0);
        chk("R10 zero no long", err_long, 1'b0);
        usync;
        chk("R10 zero no short", err_short, 1'b0);

        // R6 free-run
        cfg_sync_sel = 2'd2;
        cfg_lines = 12'd2;
        rst = 1'b1; tick; tick; rst = 1'b0;
        chk("R1 done after reset", frame_done, 1'b1);
        line;
        chk("R6 first line clears", frame_done, 1'b0);
        line;
        chk("R6 wrap done", frame_done, 1'b1);
        chk("R6 wrap irq", irq, 1'b1);
        tick;
        chk("R5 irq one cycle", irq, 1'b0);
        line;
        chk("R6 restart clears", frame_done, 1'b0);
        line;
        chk("R6 second frame irq", irq, 1'b1);
        chk("R6 no long in free", err_long, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule